// File: doc/BRIEF.md
# Prescaled Capture/Compare Timer

This block is a free-running up-counter with a selectable prescaler, one input-capture register and two compare registers. Each prescaled tick advances the counter. The prescaler can divide either the core clock or the rising edges of an external event pin. With the external source selected, the block works as an event counter. A small register interface sets the mode, reads the count and writes it.

Compare register A and compare register B each detect a match on the tick where the count equals their value. A match can return the counter to zero, which gives exact repeating periods. A match also raises a sticky flag. Compare A drives the output pin in one of two modes. In toggle mode the pin inverts on each match, which gives a square wave. In pulse mode the pin goes high at zero and low at the match, which gives a variable-width pulse. A capture input takes a hardware snapshot of the count on a chosen edge. Overflow, capture and both match events set sticky flags. Software clears them one by one, or an interrupt acknowledge clears them all at once.

Top module: `capcmp_timer`

## Requirements
- R1: With ctrl bit 2 at 0 and run (ctrl bit 0) at 1, ctrl bits 5:3 pick a fixed divide. Codes 0, 1, 2, 3 and 4 divide by 1, 8, 64, 256 and 1024. Codes 5 to 7 also divide by 1024. The count (address 2) advances once per divided tick.
- R2: With ctrl bit 2 at 1, the prescale register (address 1) holds P-1 and the counter advances once every P input pulses.
- R3: When a tick wraps the count from all ones to zero, flag bit 0 (flag register, address 6) is set. It stays set until it is cleared.
- R4: Compare A is at address 3 and compare B at address 4. When ctrl bit 6 (for A) or ctrl bit 7 (for B) is set, a tick taken while the count equals that compare value returns the count to 0. The period is then compare+1 ticks. A match on A sets flag bit 2 and a match on B sets flag bit 3.
- R5: Ctrl bit 10 enables capture on rising edges of cap_pin and ctrl bit 11 enables it on falling edges. Each input passes a two-flop synchroniser. On the third clock edge after a pin change, the capture register (address 5) loads the count as it was before that edge, and flag bit 1 is set.
- R6: In pulse mode (ctrl bits 9:8 = 2), tmr_out goes to 1 on a tick that brings the count to zero. It goes to 0 on a match of compare A.
- R7: In toggle mode (ctrl bits 9:8 = 1), tmr_out inverts on every match of compare A. Mode 0 holds tmr_out at 0.
- R8: With ctrl bit 1 set, the prescaler input is the synchronised rising edges of evt_pin instead of the clock. The block then counts events.
- R9: Writing ones to address 6 clears those flag bits. A high irq_ack clears all four flags. A flag-setting event in the same cycle as a clear leaves that flag set.
- R10: Run at 0 freezes both the counter and the prescaler. A ctrl write with bit 12 set zeroes both. Bit 12 is not stored.
- R11: After reset every register reads 0 and tmr_out is 0. A write to address 2 loads the count.
- R12: irq is high exactly when at least one flag bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | CNT_W | Read data, combinational from rd_addr |
| irq_ack | input | 1 | Interrupt acknowledge; clears all flags |
| evt_pin | input | 1 | Asynchronous external count source |
| cap_pin | input | 1 | Asynchronous capture trigger |
| tmr_out | output | 1 | Compare-driven waveform output |
| irq | output | 1 | High while any flag is set |

## Verification
On every cycle the assertions check five things: overflow raises its flag, a flag survives when no clear is applied, a clear-on-match returns the count to zero, a stopped counter holds its value, and a capture stores the prior count and raises its flag. Toggle inversion on each match A is also checked every cycle. Other behaviours only show up in the bench's scenarios against its cycle model. These are the exact prescaler divide for each code, the latency through the synchronisers, the position of the pulse edges in pulse mode, and a clear that collides with a new event.

// File: rtl/tmr_pkg.sv
// Shared definitions for the capture/compare timer: register map,
// control word layout and output-mode encoding.
package tmr_pkg;
    typedef enum logic [2:0] {
        A_CTRL  = 3'd0,
        A_PRESC = 3'd1,
        A_COUNT = 3'd2,
        A_CMPA  = 3'd3,
        A_CMPB  = 3'd4,
        A_CAPT  = 3'd5,
        A_FLAGS = 3'd6
    } reg_addr_e;

    typedef enum logic [1:0] {
        OUT_OFF    = 2'd0,
        OUT_TOGGLE = 2'd1,
        OUT_PULSE  = 2'd2,
        OUT_RSVD   = 2'd3
    } out_mode_e;

    // Stored control word, 12 bits, MSB first.
    typedef struct packed {
        logic [1:0] cap_edge;  // [11:10] bit10 rising, bit11 falling
        out_mode_e  mode;      // [9:8]
        logic       clr_b;     // [7]
        logic       clr_a;     // [6]
        logic [2:0] sel;       // [5:3] fixed divide code
        logic       prog;      // [2] programmable divide
        logic       ext;       // [1] external event source
        logic       run;       // [0]
    } ctrl_t;

    localparam int CTL_W    = 12;
    localparam int CTL_ZERO = 12;   // write-only strobe bit
    localparam int FLAG_W   = 4;    // {match_b, match_a, capture, wrap}
endpackage

// File: rtl/tmr_sync_edge.sv
// Synchroniser for one asynchronous pin.
// Assumes the pin is slower than clk. Outputs the synchronised level
// and its one-cycle-delayed copy so the caller can form edges.
module tmr_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic lvl,
    output logic lvl_d
);
    logic [STAGES:0] chain_q;

    // Shift the pin through the synchroniser flops plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-1:0], pin};
    end

    assign lvl   = chain_q[STAGES-1];
    assign lvl_d = chain_q[STAGES];
endmodule

// File: rtl/tmr_prescaler.sv
// Divides input pulses into counter ticks.
// Fixed mode uses a power-of-two table. Programmable mode divides by
// prog_m1+1. Assumes PRE_W >= 10 so a divide of 1024 fits.
module tmr_prescaler #(
    parameter int PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_in,
    input  logic             zero,
    input  logic             prog,
    input  logic [2:0]       sel,
    input  logic [PRE_W-1:0] prog_m1,
    output logic             tick
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] fix_m1;
    logic [PRE_W-1:0] div_m1;

    // Map the fixed code to divide-minus-one.
    always_comb begin
        case (sel)
            3'd0:    fix_m1 = '0;
            3'd1:    fix_m1 = PRE_W'(7);
            3'd2:    fix_m1 = PRE_W'(63);
            3'd3:    fix_m1 = PRE_W'(255);
            default: fix_m1 = PRE_W'(1023);
        endcase
        div_m1 = prog ? prog_m1 : fix_m1;
        tick   = pulse_in && (pre_q >= div_m1);
    end

    // Count input pulses and restart on each emitted tick.
    always_ff @(posedge clk) begin
        if (!rst_n)        pre_q <= '0;
        else if (zero)     pre_q <= '0;
        else if (pulse_in) pre_q <= tick ? '0 : pre_q + PRE_W'(1);
    end
endmodule

// File: rtl/tmr_counter.sv
// Main up-counter with two comparators.
// Matches are evaluated on the tick while the count equals a compare
// value. Software load wins over the zero strobe, which wins over a tick.
module tmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             zero,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    input  logic             clr_a_en,
    input  logic             clr_b_en,
    output logic [CNT_W-1:0] cnt,
    output logic             match_a,
    output logic             match_b,
    output logic             wrap,
    output logic             hit_zero
);
    logic [CNT_W-1:0] nxt;
    logic             clr_hit;

    // Decode matches, clear-on-match and the next count.
    always_comb begin
        match_a  = tick && (cnt == cmp_a);
        match_b  = tick && (cnt == cmp_b);
        clr_hit  = (clr_a_en && match_a) || (clr_b_en && match_b);
        nxt      = clr_hit ? '0 : cnt + CNT_W'(1);
        wrap     = tick && !clr_hit && (cnt == {CNT_W{1'b1}});
        hit_zero = tick && (nxt == '0);
    end

    // Count register update.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (ld)   cnt <= ld_val;
        else if (zero) cnt <= '0;
        else if (tick) cnt <= nxt;
    end
endmodule

// File: rtl/capcmp_timer.sv
// Capture/compare timer top: register file, flags, capture, output pin.
// Assumes CNT_W >= 13 (control strobe fits the bus) and PRE_W <= CNT_W.
module capcmp_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int PRE_W       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [2:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    input  logic             irq_ack,
    input  logic             evt_pin,
    input  logic             cap_pin,
    output logic             tmr_out,
    output logic             irq
);
    localparam int DW = CNT_W;

    ctrl_t             ctrl_q;
    logic [PRE_W-1:0]  presc_q;
    logic [CNT_W-1:0]  cmpa_q, cmpb_q, capt_q;
    logic [FLAG_W-1:0] flags_q;
    logic              out_q;

    logic wr_ctrl, wr_presc, wr_count, wr_cmpa, wr_cmpb, wr_flags, soft_zero;
    logic evt_lvl, evt_lvl_d, cap_lvl, cap_lvl_d;
    logic evt_rise, cap_rise, cap_fall, cap_hit;
    logic pulse_in, cnt_tick;
    logic [CNT_W-1:0] cnt_q;
    logic match_a, match_b, wrap_evt, hit_zero;
    logic [FLAG_W-1:0] flag_set, flag_clr;
    logic [CTL_W-1:0]  ctrl_bits;

    // Write decode.
    always_comb begin
        wr_ctrl   = wr_en && (wr_addr == A_CTRL);
        wr_presc  = wr_en && (wr_addr == A_PRESC);
        wr_count  = wr_en && (wr_addr == A_COUNT);
        wr_cmpa   = wr_en && (wr_addr == A_CMPA);
        wr_cmpb   = wr_en && (wr_addr == A_CMPB);
        wr_flags  = wr_en && (wr_addr == A_FLAGS);
        soft_zero = wr_ctrl && wr_data[CTL_ZERO];
    end

    tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_evt_sync (
        .clk(clk), .rst_n(rst_n), .pin(evt_pin), .lvl(evt_lvl), .lvl_d(evt_lvl_d));
    tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_cap_sync (
        .clk(clk), .rst_n(rst_n), .pin(cap_pin), .lvl(cap_lvl), .lvl_d(cap_lvl_d));

    // Edge forming, count source selection and capture trigger.
    always_comb begin
        evt_rise = evt_lvl && !evt_lvl_d;
        cap_rise = cap_lvl && !cap_lvl_d;
        cap_fall = !cap_lvl && cap_lvl_d;
        pulse_in = ctrl_q.run && (ctrl_q.ext ? evt_rise : 1'b1);
        cap_hit  = (ctrl_q.cap_edge[0] && cap_rise) || (ctrl_q.cap_edge[1] && cap_fall);
    end

    tmr_prescaler #(.PRE_W(PRE_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .zero(soft_zero),
        .prog(ctrl_q.prog), .sel(ctrl_q.sel), .prog_m1(presc_q), .tick(cnt_tick));

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(cnt_tick), .zero(soft_zero),
        .ld(wr_count), .ld_val(wr_data), .cmp_a(cmpa_q), .cmp_b(cmpb_q),
        .clr_a_en(ctrl_q.clr_a), .clr_b_en(ctrl_q.clr_b), .cnt(cnt_q),
        .match_a(match_a), .match_b(match_b), .wrap(wrap_evt), .hit_zero(hit_zero));

    // Configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            presc_q <= '0;
            cmpa_q  <= '0;
            cmpb_q  <= '0;
        end else begin
            if (wr_ctrl)  ctrl_q  <= ctrl_t'(wr_data[CTL_W-1:0]);
            if (wr_presc) presc_q <= wr_data[PRE_W-1:0];
            if (wr_cmpa)  cmpa_q  <= wr_data;
            if (wr_cmpb)  cmpb_q  <= wr_data;
        end
    end

    // Hardware snapshot of the count.
    always_ff @(posedge clk) begin
        if (!rst_n)       capt_q <= '0;
        else if (cap_hit) capt_q <= cnt_q;
    end

    // Sticky flags: a new event outranks a clear in the same cycle.
    always_comb begin
        flag_set = {match_b, match_a, cap_hit, wrap_evt};
        flag_clr = (wr_flags ? wr_data[FLAG_W-1:0] : '0) | {FLAG_W{irq_ack}};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~flag_clr) | flag_set;
    end

    // Waveform output in toggle or pulse mode.
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= 1'b0;
        else begin
            case (ctrl_q.mode)
                OUT_TOGGLE: if (match_a) out_q <= !out_q;
                OUT_PULSE: begin
                    if (hit_zero)     out_q <= 1'b1;
                    else if (match_a) out_q <= 1'b0;
                end
                default:    out_q <= 1'b0;
            endcase
        end
    end

    // Read mux.
    always_comb begin
        ctrl_bits = ctrl_q;
        case (rd_addr)
            A_CTRL:  rd_data = DW'(ctrl_bits);
            A_PRESC: rd_data = DW'(presc_q);
            A_COUNT: rd_data = cnt_q;
            A_CMPA:  rd_data = cmpa_q;
            A_CMPB:  rd_data = cmpb_q;
            A_CAPT:  rd_data = capt_q;
            A_FLAGS: rd_data = DW'(flags_q);
            default: rd_data = '0;
        endcase
    end

    assign tmr_out = out_q;
    assign irq     = |flags_q;
endmodule

// File: rtl/capcmp_timer_sva.sv
// Property checker for the capture/compare timer, bound to the top.
// Observes internal state only; drives nothing.
module tmr_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] cmpa,
    input logic [CNT_W-1:0] capt,
    input logic [3:0]       flags,
    input logic             wrap_evt,
    input logic             cap_hit,
    input logic             match_a,
    input logic             run,
    input logic             clr_a,
    input logic [1:0]       mode,
    input logic             out,
    input logic             wr_ctrl,
    input logic             wr_count,
    input logic             wr_flags,
    input logic             wr_bit0,
    input logic             soft_zero,
    input logic             irq_ack
);
    assert_wrap_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_evt |=> flags[0]);

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[0] && !(wr_flags && wr_bit0) && !irq_ack) |=> flags[0]);

    assert_clear_on_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && clr_a && (cnt == cmpa) && !wr_count && !soft_zero) |=> (cnt == '0));

    assert_stop_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_count && !soft_zero) |=> $stable(cnt));

    assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_hit |=> ((capt == $past(cnt)) && flags[1]));

    assert_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 2'd1) && match_a && !wr_ctrl) |=> (out != $past(out)));
endmodule

bind capcmp_timer tmr_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(cnt_tick), .cnt(cnt_q), .cmpa(cmpa_q),
    .capt(capt_q), .flags(flags_q), .wrap_evt(wrap_evt), .cap_hit(cap_hit),
    .match_a(match_a), .run(ctrl_q.run), .clr_a(ctrl_q.clr_a), .mode(ctrl_q.mode),
    .out(out_q), .wr_ctrl(wr_ctrl), .wr_count(wr_count), .wr_flags(wr_flags),
    .wr_bit0(wr_data[0]), .soft_zero(soft_zero), .irq_ack(irq_ack));

// File: tb/sim_capcmp_timer.sv
`timescale 1ns/1ps
module sim_capcmp_timer;
    localparam int ADR_CTRL = 0, ADR_PRESC = 1, ADR_COUNT = 2, ADR_CMPA = 3,
                   ADR_CMPB = 4, ADR_CAPT = 5, ADR_FLAGS = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = 3'd0;
    logic [15:0] wr_data = 16'd0;
    logic [2:0]  rd_addr = 3'd2;
    logic [15:0] rd_data;
    logic        irq_ack = 1'b0;
    logic        evt_pin = 1'b0;
    logic        cap_pin = 1'b0;
    logic        tmr_out, irq;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    capcmp_timer u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq_ack(irq_ack), .evt_pin(evt_pin),
        .cap_pin(cap_pin), .tmr_out(tmr_out), .irq(irq));

    always #2 clk = ~clk;

    // ---------------- behavioural reference model ----------------
    bit [15:0] m_ctrl, m_presc, m_cnt, m_cmpa, m_cmpb, m_capt;
    bit [11:0] m_pre;
    bit [3:0]  m_flags;
    bit        m_out;
    bit        eh [0:2];
    bit        ch [0:2];
    int        div, mode, edg;
    bit        pin_in, tk, ma, mb, clr, wrp, caphit, erise, crise, cfall;
    bit [15:0] nx;
    bit [3:0]  clrv;

    function automatic int fixed_div(int code);
        case (code)
            0: return 1;
            1: return 8;
            2: return 64;
            3: return 256;
            default: return 1024;
        endcase
    endfunction

    function automatic bit [15:0] mread(int a);
        case (a)
            ADR_CTRL:  return m_ctrl;
            ADR_PRESC: return m_presc;
            ADR_COUNT: return m_cnt;
            ADR_CMPA:  return m_cmpa;
            ADR_CMPB:  return m_cmpb;
            ADR_CAPT:  return m_capt;
            ADR_FLAGS: return {12'd0, m_flags};
            default:   return 16'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_ctrl = 0; m_presc = 0; m_cnt = 0; m_cmpa = 0; m_cmpb = 0; m_capt = 0;
            m_pre = 0; m_flags = 0; m_out = 0;
            for (int i = 0; i < 3; i++) begin eh[i] = 0; ch[i] = 0; end
        end else begin
            erise  = eh[1] && !eh[2];
            crise  = ch[1] && !ch[2];
            cfall  = !ch[1] && ch[2];
            pin_in = m_ctrl[0] && (m_ctrl[1] ? erise : 1'b1);
            div    = m_ctrl[2] ? int'(m_presc) + 1 : fixed_div(int'(m_ctrl[5:3]));
            tk     = pin_in && (int'(m_pre) >= div - 1);
            ma     = tk && (m_cnt == m_cmpa);
            mb     = tk && (m_cnt == m_cmpb);
            clr    = (m_ctrl[6] && ma) || (m_ctrl[7] && mb);
            nx     = clr ? 16'd0 : m_cnt + 16'd1;
            wrp    = tk && !clr && (m_cnt == 16'hFFFF);
            edg    = int'(m_ctrl[11:10]);
            mode   = int'(m_ctrl[9:8]);
            caphit = (edg[0] && crise) || (edg[1] && cfall);
            if (caphit) m_capt = m_cnt;
            clrv = ((wr_en && wr_addr == 3'(ADR_FLAGS)) ? wr_data[3:0] : 4'd0) | {4{irq_ack}};
            m_flags = (m_flags & ~clrv) | {mb, ma, caphit, wrp};
            if (mode == 1) begin
                if (ma) m_out = !m_out;
            end else if (mode == 2) begin
                if (tk && nx == 16'd0) m_out = 1'b1;
                else if (ma)           m_out = 1'b0;
            end else m_out = 1'b0;
            if (wr_en && wr_addr == 3'(ADR_CTRL) && wr_data[12]) m_pre = 0;
            else if (pin_in) m_pre = tk ? 12'd0 : m_pre + 12'd1;
            if (wr_en && wr_addr == 3'(ADR_COUNT))                    m_cnt = wr_data;
            else if (wr_en && wr_addr == 3'(ADR_CTRL) && wr_data[12]) m_cnt = 0;
            else if (tk)                                              m_cnt = nx;
            if (wr_en && wr_addr == 3'(ADR_CTRL))  m_ctrl  = {4'd0, wr_data[11:0]};
            if (wr_en && wr_addr == 3'(ADR_PRESC)) m_presc = {4'd0, wr_data[11:0]};
            if (wr_en && wr_addr == 3'(ADR_CMPA))  m_cmpa  = wr_data;
            if (wr_en && wr_addr == 3'(ADR_CMPB))  m_cmpb  = wr_data;
            eh[2] = eh[1]; eh[1] = eh[0]; eh[0] = evt_pin;
            ch[2] = ch[1]; ch[1] = ch[0]; ch[0] = cap_pin;
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (cyc > 2) begin
            checks++;
            if (rd_data !== mread(int'(rd_addr)) || tmr_out !== m_out || irq !== (|m_flags)) begin
                fails++;
                $display("FAIL R12/model cycle %0d: rd[%0d] %0h/%0h out %b/%b irq %b/%b",
                         cyc, rd_addr, rd_data, mread(int'(rd_addr)), tmr_out, m_out, irq, |m_flags);
            end
        end
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wait_n(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input int a, input int d);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic rd(input int a, output int v);
        rd_addr = 3'(a);
        #0.5;
        v = int'(rd_data);
        rd_addr = 3'(ADR_COUNT);
    endtask

    function automatic int ctl(int run, int ext, int prog, int sel, int ca, int cb,
                               int md, int eg, int zero);
        return run | (ext << 1) | (prog << 2) | (sel << 3) | (ca << 6) | (cb << 7) |
               (md << 8) | (eg << 10) | (zero << 12);
    endfunction

    int v;

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        // R11 reset state
        rd(ADR_COUNT, v); chk("R11 count after reset", v, 0);
        rd(ADR_FLAGS, v); chk("R11 flags after reset", v, 0);
        chk("R11 out after reset", int'(tmr_out), 0);
        chk("R12 irq after reset", int'(irq), 0);

        // R1 fixed divides
        wr(ADR_CTRL, ctl(1,0,0,1,0,0,0,0,1)); wait_n(40);
        rd(ADR_COUNT, v); chk("R1 divide 8", v, 5);
        wr(ADR_CTRL, ctl(1,0,0,4,0,0,0,0,1)); wait_n(3000);
        rd(ADR_COUNT, v); chk("R1 divide 1024", v, 2);
        wr(ADR_CTRL, ctl(1,0,0,7,0,0,0,0,1)); wait_n(3000);
        rd(ADR_COUNT, v); chk("R1 code 7 divides by 1024", v, 2);

        // R2 programmable divide by 5
        wr(ADR_PRESC, 4);
        wr(ADR_CTRL, ctl(1,0,1,0,0,0,0,0,1)); wait_n(23);
        rd(ADR_COUNT, v); chk("R2 divide 5", v, 4);

        // R3 overflow
        wr(ADR_CMPA, 100); wr(ADR_CMPB, 200);
        wr(ADR_CTRL, 0); wr(ADR_FLAGS, 15);
        wr(ADR_COUNT, 16'hFFFD);
        rd(ADR_COUNT, v); chk("R11 count load", v, 16'hFFFD);
        wr(ADR_CTRL, ctl(1,0,0,0,0,0,0,0,0)); wait_n(5);
        rd(ADR_COUNT, v); chk("R3 count after wrap", v, 2);
        rd(ADR_FLAGS, v); chk("R3 wrap flag", v, 1);
        chk("R12 irq with flag", int'(irq), 1);
        wait_n(10);
        rd(ADR_FLAGS, v); chk("R3 wrap flag sticky", v, 1);
        wr(ADR_FLAGS, 1);
        rd(ADR_FLAGS, v); chk("R9 write-one clear", v, 0);

        // R9 set wins over clear, then acknowledge
        wr(ADR_CTRL, 0); wr(ADR_COUNT, 16'hFFFE);
        wr(ADR_CTRL, ctl(1,0,0,0,0,0,0,0,0)); wait_n(1);
        wr(ADR_FLAGS, 15);
        rd(ADR_FLAGS, v); chk("R9 set beats clear", v, 1);
        irq_ack = 1'b1; wait_n(1); irq_ack = 1'b0;
        rd(ADR_FLAGS, v); chk("R9 acknowledge clears", v, 0);
        chk("R12 irq low after ack", int'(irq), 0);

        // R4 clear on match A then B
        wr(ADR_CMPA, 9);
        wr(ADR_CTRL, ctl(1,0,0,0,1,0,0,0,1)); wait_n(25);
        rd(ADR_COUNT, v); chk("R4 period 10", v, 5);
        rd(ADR_FLAGS, v); chk("R4 match A flag", v & 4, 4);
        wr(ADR_CMPB, 4);
        wr(ADR_CTRL, ctl(1,0,0,0,0,1,0,0,1)); wait_n(23);
        rd(ADR_COUNT, v); chk("R4 period 5 via B", v, 3);
        rd(ADR_FLAGS, v); chk("R4 match B flag", v & 8, 8);

        // R7 toggle
        wr(ADR_CMPA, 3); wr(ADR_CTRL, 0);
        wr(ADR_CTRL, ctl(1,0,0,0,1,0,1,0,1)); wait_n(5);
        chk("R7 toggle high", int'(tmr_out), 1);
        wait_n(4);
        chk("R7 toggle low", int'(tmr_out), 0);

        // R6 pulse
        wr(ADR_CMPA, 2); wr(ADR_CMPB, 5); wr(ADR_CTRL, 0);
        wr(ADR_CTRL, ctl(1,0,0,0,0,1,2,0,1)); wait_n(7);
        chk("R6 pulse set at zero", int'(tmr_out), 1);
        wait_n(3);
        chk("R6 pulse cleared by match A", int'(tmr_out), 0);
        wait_n(2);
        chk("R6 pulse set again", int'(tmr_out), 1);

        // R5 capture on rising then falling edge
        wr(ADR_CTRL, 0); wr(ADR_FLAGS, 15);
        wr(ADR_CMPA, 1000); wr(ADR_CMPB, 1000);
        wr(ADR_CTRL, ctl(1,0,0,0,0,0,0,1,1));
        cap_pin = 1'b1; wait_n(6);
        rd(ADR_CAPT, v); chk("R5 rising capture", v, 2);
        rd(ADR_FLAGS, v); chk("R5 capture flag", v & 2, 2);
        wr(ADR_CTRL, ctl(1,0,0,0,0,0,0,2,1)); wait_n(10);
        cap_pin = 1'b0; wait_n(5);
        rd(ADR_CAPT, v); chk("R5 falling capture", v, 12);

        // R8 external events
        wr(ADR_CTRL, ctl(1,1,0,0,0,0,0,0,1));
        for (int k = 0; k < 5; k++) begin
            evt_pin = 1'b1; wait_n(2);
            evt_pin = 1'b0; wait_n(2);
        end
        wait_n(4);
        rd(ADR_COUNT, v); chk("R8 event count", v, 5);

        // R10 stop and zero strobe
        wr(ADR_CTRL, ctl(1,0,0,0,0,0,0,0,1)); wait_n(7);
        wr(ADR_CTRL, 0); wait_n(10);
        rd(ADR_COUNT, v); chk("R10 stopped count", v, 8);
        wr(ADR_CTRL, ctl(0,0,0,0,0,0,0,0,1));
        rd(ADR_COUNT, v); chk("R10 zero strobe", v, 0);
        rd(ADR_CTRL, v); chk("R10 strobe not stored", v, 0);

        wait_n(3);
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule